// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block couples two processors, called side A and side B, through a pair of mirrored 32-bit register banks that share one clock. Each side has four outgoing mailbox words and four incoming mailbox words. A word that one side posts into an outgoing slot shows up in the matching incoming slot of the other side. A full flag for each slot and each direction tracks which side owns the word, so a sender cannot overwrite a word the receiver has not yet read. Four doorbells in each direction let one side raise an event on the other without sending data.

Each side has one interrupt line. The line combines every flag of that side with the enable bits that side has set. Bus accesses are single-cycle. A side drives `sel` together with `wr`, a byte address and write data. Read data is returned combinationally in the same cycle, and any side effect of the access takes place at the next rising clock edge.

Top module: `ipc_msg_unit`

## Requirements
- R1: The word index is addr[5:2], and addr[1:0] is ignored. Index 0..3 selects outgoing slot n, which reads back the last word accepted. Index 4..7 selects incoming slot n. Index 8 is the status word and index 9 is the control word. Any other index reads 0 and ignores writes.
- R2: A write to outgoing slot n, made while that side's empty flag for n is 1, stores the word. From the next cycle the other side reads the word from incoming slot n, the other side's full flag n reads 1, and the writer's empty flag n reads 0.
- R3: A read of incoming slot n while its full flag is 1 clears that flag and sets the sender's empty flag n from the next cycle. A read while the flag is 0 returns the held word and changes nothing.
- R4: A write to outgoing slot n while the empty flag n is 0 is dropped, and the word already held is kept.
- R5: Status word layout for channel n: doorbell-pending at bit 28+(3-n), incoming-full at bit 24+(3-n), outgoing-empty at bit 20+(3-n). Bit 9 is a spare pending flag that has no set source under the common reset and reads 0. All other bits read 0.
- R6: Control word layout for channel n: doorbell enable at bit 28+(3-n), incoming enable at bit 24+(3-n), outgoing enable at bit 23-n. These bits are read/write. The doorbell request is at bit 16+(3-n).
- R7: Writing 1 to request bit n sets the other side's pending bit n at the next edge. The request reads 1 for exactly one cycle and then clears itself. Writing 0 never cancels a request.
- R8: Writing 1 to a pending bit in the status word clears that bit, and writing 0 leaves it unchanged. No other status bit is writable. If a clear and a new doorbell arrive in the same cycle, the pending bit stays set.
- R9: A side's interrupt is 1 exactly when some status flag of that side and its matching enable are both 1.
- R10: After reset the control words are 0, every empty flag is 1, every full, pending and request bit is 0, the data is 0 and both interrupts are 0.
- R11: Both sides may access the block in the same cycle, and each access takes effect as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, same cycle |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, same cycle |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its default values: four channels and 32-bit words. With these values every status and control bit position lies inside one bus word, so the reversed bit layout can be checked in full. Directed cycles cover the dropped write into a full slot, a read from an empty slot, a doorbell request that lasts one cycle, and a clear that meets a new doorbell in the same cycle. A long run of random same-cycle traffic on both sides then drives overlaps of writes, reads and doorbells across all four channels.

// File: rtl/ipc_msg_pkg.sv
package ipc_msg_pkg;
    localparam int DW        = 32;
    localparam int AW        = 6;
    localparam int NCH       = 4;
    localparam int WSEL_W    = AW - 2;
    localparam int CIDX_W    = $clog2(NCH);
    localparam int GIP_LSB   = 28;
    localparam int RF_LSB    = 24;
    localparam int TE_LSB    = 20;
    localparam int GIR_LSB   = 16;
    localparam int WORD_STAT = 2 * NCH;
    localparam int WORD_CTRL = 2 * NCH + 1;

    typedef enum logic [2:0] {RK_TX, RK_RX, RK_STAT, RK_CTRL, RK_NONE} reg_kind_e;

    typedef struct packed {
        logic [NCH-1:0] gie;
        logic [NCH-1:0] rie;
        logic [NCH-1:0] tie;
    } ctrl_t;

    function automatic reg_kind_e decode_word(input logic [WSEL_W-1:0] w);
        if (int'(w) < NCH)           return RK_TX;
        else if (int'(w) < 2 * NCH)  return RK_RX;
        else if (int'(w) == WORD_STAT) return RK_STAT;
        else if (int'(w) == WORD_CTRL) return RK_CTRL;
        return RK_NONE;
    endfunction

    // channel 0 sits in the top bit of each group
    function automatic logic [NCH-1:0] chan_rev(input logic [NCH-1:0] v);
        logic [NCH-1:0] r;
        for (int n = 0; n < NCH; n++) r[n] = v[NCH-1-n];
        return r;
    endfunction

    function automatic logic [NCH-1:0] field_get(input logic [DW-1:0] word, input int lsb);
        return chan_rev(word[lsb +: NCH]);
    endfunction

    function automatic logic [DW-1:0] field_put(input logic [NCH-1:0] v, input int lsb);
        logic [DW-1:0] r;
        r = '0;
        r[lsb +: NCH] = chan_rev(v);
        return r;
    endfunction
endpackage

// File: rtl/ipc_chan_link.sv
module ipc_chan_link #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    output logic [WORD_W-1:0] data,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else if (wr_en && !full) begin
            data <= wdata;
            full <= 1'b1;
        end else if (rd_en && full) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/ipc_side_bank.sv
module ipc_side_bank
    import ipc_msg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    wr,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [NCH-1:0]          tx_full,
    input  logic [NCH-1:0]          rx_full,
    input  logic [NCH-1:0][DW-1:0]  tx_data,
    input  logic [NCH-1:0][DW-1:0]  rx_data,
    input  logic [NCH-1:0]          db_in,
    output logic [DW-1:0]           rdata,
    output logic                    irq,
    output logic [NCH-1:0]          tx_wr,
    output logic [NCH-1:0]          rx_rd,
    output logic [NCH-1:0]          gir
);
    logic [WSEL_W-1:0] word;
    logic [CIDX_W-1:0] cidx;
    reg_kind_e         kind;
    logic              wr_en, rd_en;
    ctrl_t             ctrl;
    logic [NCH-1:0]    gip, w1c;
    logic              unused_lsb;

    assign word       = addr[AW-1:2];
    assign cidx       = word[CIDX_W-1:0];
    assign kind       = decode_word(word);
    assign wr_en      = sel && wr;
    assign rd_en      = sel && !wr;
    assign unused_lsb = ^addr[1:0];
    assign w1c        = (wr_en && kind == RK_STAT) ? field_get(wdata, GIP_LSB) : '0;

    always_comb begin
        tx_wr = '0;
        rx_rd = '0;
        if (wr_en && kind == RK_TX) tx_wr[cidx] = 1'b1;
        if (rd_en && kind == RK_RX) rx_rd[cidx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            gip  <= '0;
            gir  <= '0;
        end else begin
            if (wr_en && kind == RK_CTRL) begin
                ctrl <= '{gie: field_get(wdata, GIP_LSB),
                          rie: field_get(wdata, RF_LSB),
                          tie: field_get(wdata, TE_LSB)};
            end
            gir <= (wr_en && kind == RK_CTRL) ? field_get(wdata, GIR_LSB) : '0;
            gip <= (gip & ~w1c) | db_in;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (kind)
                RK_TX:   rdata = tx_data[cidx];
                RK_RX:   rdata = rx_data[cidx];
                RK_STAT: rdata = field_put(gip, GIP_LSB) | field_put(rx_full, RF_LSB)
                               | field_put(~tx_full, TE_LSB);
                RK_CTRL: rdata = field_put(ctrl.gie, GIP_LSB) | field_put(ctrl.rie, RF_LSB)
                               | field_put(ctrl.tie, TE_LSB) | field_put(gir, GIR_LSB);
                default: rdata = '0;
            endcase
        end
    end

    assign irq = |((gip & ctrl.gie) | (rx_full & ctrl.rie) | (~tx_full & ctrl.tie));
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit
    import ipc_msg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NCH-1:0][DW-1:0] ab_data, ba_data;
    logic [NCH-1:0]         ab_full, ba_full;
    logic [NCH-1:0]         a_tx_wr, a_rx_rd, a_gir;
    logic [NCH-1:0]         b_tx_wr, b_rx_rd, b_gir;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        ipc_chan_link #(.WORD_W(DW)) u_ab (
            .clk(clk), .rst(rst), .wr_en(a_tx_wr[n]), .wdata(a_wdata),
            .rd_en(b_rx_rd[n]), .data(ab_data[n]), .full(ab_full[n]));
        ipc_chan_link #(.WORD_W(DW)) u_ba (
            .clk(clk), .rst(rst), .wr_en(b_tx_wr[n]), .wdata(b_wdata),
            .rd_en(a_rx_rd[n]), .data(ba_data[n]), .full(ba_full[n]));
    end

    ipc_side_bank u_side_a (
        .clk(clk), .rst(rst), .sel(a_sel), .wr(a_wr), .addr(a_addr), .wdata(a_wdata),
        .tx_full(ab_full), .rx_full(ba_full), .tx_data(ab_data), .rx_data(ba_data),
        .db_in(b_gir), .rdata(a_rdata), .irq(a_irq),
        .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .gir(a_gir));

    ipc_side_bank u_side_b (
        .clk(clk), .rst(rst), .sel(b_sel), .wr(b_wr), .addr(b_addr), .wdata(b_wdata),
        .tx_full(ba_full), .rx_full(ab_full), .tx_data(ba_data), .rx_data(ab_data),
        .db_in(a_gir), .rdata(b_rdata), .irq(b_irq),
        .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .gir(b_gir));
endmodule

// File: rtl/ipc_msg_unit_chk.sv
module ipc_msg_unit_chk
    import ipc_msg_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [DW-1:0]          a_wdata,
    input logic [DW-1:0]          b_wdata,
    input logic [NCH-1:0]         a_tx_wr,
    input logic [NCH-1:0]         b_tx_wr,
    input logic [NCH-1:0]         a_rx_rd,
    input logic [NCH-1:0]         b_rx_rd,
    input logic [NCH-1:0]         ab_full,
    input logic [NCH-1:0]         ba_full,
    input logic [NCH-1:0][DW-1:0] ab_data,
    input logic [NCH-1:0][DW-1:0] ba_data,
    input logic                   a_irq,
    input logic                   b_irq
);
    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_irq && !b_irq));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        p_accept_ab_r2: assert property (@(posedge clk) disable iff (rst)
            (a_tx_wr[n] && !ab_full[n]) |=> (ab_full[n] && ab_data[n] == $past(a_wdata)));
        p_accept_ba_r2: assert property (@(posedge clk) disable iff (rst)
            (b_tx_wr[n] && !ba_full[n]) |=> (ba_full[n] && ba_data[n] == $past(b_wdata)));
        p_hold_ab_r4: assert property (@(posedge clk) disable iff (rst)
            (a_tx_wr[n] && ab_full[n] && !b_rx_rd[n]) |=> (ab_full[n] && $stable(ab_data[n])));
        p_hold_ba_r4: assert property (@(posedge clk) disable iff (rst)
            (b_tx_wr[n] && ba_full[n] && !a_rx_rd[n]) |=> (ba_full[n] && $stable(ba_data[n])));
        p_drain_ab_r3: assert property (@(posedge clk) disable iff (rst)
            (b_rx_rd[n] && ab_full[n]) |=> !ab_full[n]);
        p_drain_ba_r3: assert property (@(posedge clk) disable iff (rst)
            (a_rx_rd[n] && ba_full[n]) |=> !ba_full[n]);
        p_empty_read_ab_r3: assert property (@(posedge clk) disable iff (rst)
            (b_rx_rd[n] && !ab_full[n] && !a_tx_wr[n]) |=> (!ab_full[n] && $stable(ab_data[n])));
    end
endmodule

bind ipc_msg_unit ipc_msg_unit_chk chk_i (
    .clk(clk), .rst(rst), .a_wdata(a_wdata), .b_wdata(b_wdata),
    .a_tx_wr(a_tx_wr), .b_tx_wr(b_tx_wr), .a_rx_rd(a_rx_rd), .b_rx_rd(b_rx_rd),
    .ab_full(ab_full), .ba_full(ba_full), .ab_data(ab_data), .ba_data(ba_data),
    .a_irq(a_irq), .b_irq(b_irq));

// File: tb/ipc_msg_unit_tb_top.sv
`timescale 1ns/1ps
module ipc_msg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        a_sel, a_wr, b_sel, b_wr;
    logic [5:0]  a_addr, b_addr;
    logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int fails  = 0;

    // reference state: direction 0 = A to B, direction 1 = B to A
    logic [31:0] m_dat  [2][4];
    bit          m_full [2][4];
    bit          m_gip  [2][4];
    bit          m_gir  [2][4];
    bit          m_gie  [2][4];
    bit          m_rie  [2][4];
    bit          m_tie  [2][4];

    always #2.5 clk = ~clk;

    ipc_msg_unit dut_i (
        .clk(clk), .rst(rst),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq));

    function automatic logic [31:0] m_read(input int s, input logic [5:0] addr);
        int w;
        logic [31:0] r;
        w = int'(addr[5:2]);
        r = '0;
        if (w < 4) r = m_dat[s][w];
        else if (w < 8) r = m_dat[1-s][w-4];
        else if (w == 8) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_gip[s][n];
                r[27-n] = m_full[1-s][n];
                r[23-n] = !m_full[s][n];
            end
        end else if (w == 9) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_gie[s][n];
                r[27-n] = m_rie[s][n];
                r[23-n] = m_tie[s][n];
                r[19-n] = m_gir[s][n];
            end
        end
        return r;
    endfunction

    function automatic bit m_irq(input int s);
        bit r = 0;
        for (int n = 0; n < 4; n++)
            r |= (m_gip[s][n] && m_gie[s][n]) || (m_full[1-s][n] && m_rie[s][n])
               || (!m_full[s][n] && m_tie[s][n]);
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                m_dat[s][n] = '0; m_full[s][n] = 0; m_gip[s][n] = 0; m_gir[s][n] = 0;
                m_gie[s][n] = 0;  m_rie[s][n] = 0;  m_tie[s][n] = 0;
            end
    endtask

    // one clock of traffic on both sides, compared against the reference
    task automatic cyc(input bit as, input bit aw, input logic [5:0] aa, input logic [31:0] ad,
                       input bit bs, input bit bw, input logic [5:0] ba, input logic [31:0] bd,
                       input string tag);
        bit          o_full [2][4];
        bit          o_gir  [2][4];
        bit          clr    [2][4];
        bit          ngir   [2][4];
        bit          sel_v [2];
        bit          wr_v  [2];
        logic [5:0]  ad_v  [2];
        logic [31:0] wd_v  [2];
        @(negedge clk);
        a_sel = as; a_wr = aw; a_addr = aa; a_wdata = ad;
        b_sel = bs; b_wr = bw; b_addr = ba; b_wdata = bd;
        #1;
        if (as && !aw) chk(tag, "a_rdata", a_rdata, m_read(0, aa));
        if (bs && !bw) chk(tag, "b_rdata", b_rdata, m_read(1, ba));
        chk(tag, "a_irq", {31'b0, a_irq}, {31'b0, m_irq(0)});
        chk(tag, "b_irq", {31'b0, b_irq}, {31'b0, m_irq(1)});
        o_full = m_full; o_gir = m_gir;
        sel_v[0] = as; wr_v[0] = aw; ad_v[0] = aa; wd_v[0] = ad;
        sel_v[1] = bs; wr_v[1] = bw; ad_v[1] = ba; wd_v[1] = bd;
        for (int s = 0; s < 2; s++) begin
            int w;
            w = int'(ad_v[s][5:2]);
            for (int n = 0; n < 4; n++) begin clr[s][n] = 0; ngir[s][n] = 0; end
            if (sel_v[s] && wr_v[s]) begin
                if (w < 4 && !o_full[s][w]) begin
                    m_dat[s][w] = wd_v[s]; m_full[s][w] = 1;
                end else if (w == 8) begin
                    for (int n = 0; n < 4; n++) clr[s][n] = wd_v[s][31-n];
                end else if (w == 9) begin
                    for (int n = 0; n < 4; n++) begin
                        m_gie[s][n] = wd_v[s][31-n]; m_rie[s][n] = wd_v[s][27-n];
                        m_tie[s][n] = wd_v[s][23-n]; ngir[s][n]  = wd_v[s][19-n];
                    end
                end
            end
            if (sel_v[s] && !wr_v[s] && w >= 4 && w < 8 && o_full[1-s][w-4])
                m_full[1-s][w-4] = 0;
        end
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                m_gip[s][n] = (m_gip[s][n] && !clr[s][n]) || o_gir[1-s][n];
                m_gir[s][n] = ngir[s][n];
            end
    endtask

    task automatic aw_t(input logic [5:0] ad, input logic [31:0] d, input string t);
        cyc(1, 1, ad, d, 0, 0, 6'h0, 32'h0, t);
    endtask
    task automatic ar_t(input logic [5:0] ad, input string t);
        cyc(1, 0, ad, 32'h0, 0, 0, 6'h0, 32'h0, t);
    endtask
    task automatic bw_t(input logic [5:0] ad, input logic [31:0] d, input string t);
        cyc(0, 0, 6'h0, 32'h0, 1, 1, ad, d, t);
    endtask
    task automatic br_t(input logic [5:0] ad, input string t);
        cyc(0, 0, 6'h0, 32'h0, 1, 0, ad, 32'h0, t);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog R11: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_sel = 0; a_wr = 0; a_addr = '0; a_wdata = '0;
        b_sel = 0; b_wr = 0; b_addr = '0; b_wdata = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10: reset values
        cyc(1, 0, 6'h20, 0, 1, 0, 6'h20, 0, "R10");
        cyc(1, 0, 6'h24, 0, 1, 0, 6'h24, 0, "R10");
        cyc(1, 0, 6'h10, 0, 1, 0, 6'h1C, 0, "R10");
        chk("R10", "status_a", m_read(0, 6'h20), 32'h00F0_0000);

        // R1: decode, unused offsets, ignored low address bits
        ar_t(6'h28, "R1");
        aw_t(6'h2C, 32'hFFFF_FFFF, "R1");
        ar_t(6'h23, "R1");
        ar_t(6'h2C, "R1");

        // R2 / R3: transfer A to B on channel 0
        aw_t(6'h00, 32'hA0A0_0001, "R2");
        br_t(6'h20, "R2");
        ar_t(6'h20, "R2");
        chk("R2", "status_b_model", m_read(1, 6'h20), 32'h08F0_0000);
        br_t(6'h10, "R3");
        ar_t(6'h20, "R3");
        ar_t(6'h00, "R1");

        // R4: dropped write into a full slot
        aw_t(6'h04, 32'h1111_1111, "R4");
        aw_t(6'h04, 32'h2222_2222, "R4");
        ar_t(6'h04, "R4");
        br_t(6'h14, "R4");
        chk("R4", "rx1_model", m_read(1, 6'h14), 32'h1111_1111);
        // R3: read of an empty slot
        br_t(6'h14, "R3");
        br_t(6'h20, "R3");

        // R6: control read/write and layout
        bw_t(6'h24, 32'hFFFF_FFFF, "R6");
        br_t(6'h24, "R6");
        br_t(6'h24, "R6");
        bw_t(6'h24, 32'h0000_0000, "R6");

        // R9: interrupt from enables
        aw_t(6'h24, 32'h00F0_0000, "R9");
        ar_t(6'h20, "R9");
        aw_t(6'h24, 32'h0, "R9");
        bw_t(6'h24, 32'h0200_0000, "R9");
        aw_t(6'h08, 32'hC0DE_0002, "R9");
        br_t(6'h20, "R9");
        br_t(6'h18, "R9");
        bw_t(6'h24, 32'h0, "R9");

        // R7: doorbell request on channel 3
        bw_t(6'h24, 32'h1000_0000, "R7");
        aw_t(6'h24, 32'h0001_0000, "R7");
        ar_t(6'h24, "R7");
        ar_t(6'h24, "R7");
        br_t(6'h20, "R7");
        aw_t(6'h24, 32'h0, "R7");
        br_t(6'h20, "R7");

        // R8: clear rules
        bw_t(6'h20, 32'h0000_0000, "R8");
        br_t(6'h20, "R8");
        bw_t(6'h20, 32'h0FFF_FFFF, "R8");
        br_t(6'h20, "R8");
        bw_t(6'h20, 32'h1000_0000, "R8");
        br_t(6'h20, "R8");
        // set and clear meet on channel 0
        aw_t(6'h24, 32'h0008_0000, "R8");
        bw_t(6'h20, 32'h8000_0000, "R8");
        br_t(6'h20, "R8");
        bw_t(6'h20, 32'hF000_0000, "R8");
        br_t(6'h20, "R5");

        // R11: same-cycle traffic on both sides
        cyc(1, 1, 6'h0C, 32'hAAAA_0003, 1, 1, 6'h0C, 32'hBBBB_0003, "R11");
        cyc(1, 0, 6'h20, 0, 1, 0, 6'h20, 0, "R11");
        cyc(1, 0, 6'h1C, 0, 1, 0, 6'h1C, 0, "R11");
        cyc(1, 0, 6'h20, 0, 1, 0, 6'h20, 0, "R5");

        for (int i = 0; i < 2000; i++) begin
            logic [5:0] aa, ba;
            aa = {4'($urandom_range(0, 10)), 2'($urandom_range(0, 3))};
            ba = {4'($urandom_range(0, 10)), 2'($urandom_range(0, 3))};
            cyc(1'($urandom), 1'($urandom), aa, $urandom,
                1'($urandom), 1'($urandom), ba, $urandom, "R11");
        end

        summary();
        $finish;
    end
endmodule